// File: doc/BRIEF.md
# Multi-Channel Periodic Tick Timer

This block is a register-mapped peripheral with a configurable number of independent down-counting timer channels, all governed by one module control register. A channel that is switched on loads its period value, counts down once per clock and reloads by itself when it passes zero. Each expiry sets a sticky flag, and the flag can drive that channel's own interrupt line. Software clears the flag by writing a one to it.

The bus side is a plain 32-bit word-addressed read/write port. Writes take effect at the clock edge on which `wr_en` is high. Reads are combinational from `addr` while `rd_en` is high. The first two channels can be cascaded so that the second one counts expiries of the first, which gives a 64-bit span. A module-wide stop bit and a freeze bit qualify all counting. The freeze bit acts only while the external `freeze_in` pin is high.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the module control word reads 0x2 (bit 0 freeze enable = 0, bit 1 module stop = 1), every channel register reads 0, and all interrupt lines are low.
- R2: Word addresses: module control at 0x00; channel n at 0x40+4n, with load at +0, live count at +1, control at +2 and flag at +3. Reads of any other address return 0 and writes to them change nothing; writes to the live count register are ignored.
- R3: While module stop (control bit 1) is set, no counter changes value and no flag is set.
- R4: After control bit 0 goes from 0 to 1, the counter takes the load value on the next clock and then decrements once per clock; the live count register shows it.
- R5: A running counter at zero reloads the load value and sets flag bit 0 on the next clock, so it expires every load+1 cycles; the full 32-bit load range is accepted.
- R6: A load write while the channel runs does not change the ongoing countdown; the new value is used at the next reload, or at once after writing control 0 and then re-enabling.
- R7: Writing 1 to flag bit 0 clears the flag, writing 0 leaves it unchanged, and an expiry in the same cycle as the clear keeps the flag set.
- R8: A channel's interrupt line is high exactly when its flag is set and its control bit 1 is set.
- R9: While `freeze_in` is high and module control bit 0 is set, counters hold; with bit 0 clear, `freeze_in` has no effect.
- R10: Control bit 2 of channel 1 makes it decrement once per expiry of channel 0 instead of once per clock; on other channels bit 2 reads back 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_in | input | 1 | External freeze request |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read enable |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when not reading or unmapped |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench builds the block with four channels, 32-bit data and an 8-bit word address. That is enough to have a cascaded pair plus two free channels, and enough address space to reach unmapped words just below and just above the channel window. Periods are kept short so that reloads, expiry cadence and the cascade ratio can be counted cycle by cycle. A load of all ones checks the top of the counter range without waiting for it to expire.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int unsigned MCR_WORD    = 0;
  localparam int unsigned CH_BASE     = 'h40;
  localparam int unsigned CH_STRIDE   = 4;
  localparam int unsigned OFS_LOAD    = 0;
  localparam int unsigned OFS_COUNT   = 1;
  localparam int unsigned OFS_CTRL    = 2;
  localparam int unsigned OFS_FLAG    = 3;
  localparam int unsigned CTRL_W      = 3;

  // word address of register k of channel n
  function automatic int unsigned ch_word(input int unsigned n, input int unsigned k);
    return CH_BASE + n * CH_STRIDE + k;
  endfunction

  // one counting step: wrap to the load value after zero
  function automatic logic [31:0] next_count(input logic [31:0] cnt, input logic [31:0] ld);
    return (cnt == 32'd0) ? ld : cnt - 32'd1;
  endfunction
endpackage

// File: rtl/ttb_decode.sv
module ttb_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              mcr_hit,
  output logic [NUM_CH-1:0] ld_hit,
  output logic [NUM_CH-1:0] cnt_hit,
  output logic [NUM_CH-1:0] ctrl_hit,
  output logic [NUM_CH-1:0] flag_hit,
  output logic              mcr_wr,
  output logic [NUM_CH-1:0] ld_wr,
  output logic [NUM_CH-1:0] ctrl_wr,
  output logic [NUM_CH-1:0] flag_wr
);
  import ttb_pkg::*;

  assign mcr_hit = (addr == ADDR_W'(MCR_WORD));
  assign mcr_wr  = wr_en && mcr_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ld_hit[i]   = (addr == ADDR_W'(ch_word(i, OFS_LOAD)));
    assign cnt_hit[i]  = (addr == ADDR_W'(ch_word(i, OFS_COUNT)));
    assign ctrl_hit[i] = (addr == ADDR_W'(ch_word(i, OFS_CTRL)));
    assign flag_hit[i] = (addr == ADDR_W'(ch_word(i, OFS_FLAG)));
    assign ld_wr[i]    = wr_en && ld_hit[i];
    assign ctrl_wr[i]  = wr_en && ctrl_hit[i];
    assign flag_wr[i]  = wr_en && flag_hit[i];
  end
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel #(
  parameter int unsigned DATA_W    = 32,
  parameter bit          CAN_CHAIN = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       chain_in,
  input  logic                       ld_wr,
  input  logic                       ctrl_wr,
  input  logic                       flag_wr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          ld_q,
  output logic [DATA_W-1:0]          cnt_q,
  output logic [ttb_pkg::CTRL_W-1:0] ctrl_q,
  output logic                       flag_q,
  output logic                       expire,
  output logic                       irq
);
  import ttb_pkg::*;

  logic started_q;
  logic ten, tie, chain_sel;
  logic tick, load_now, step;
  logic clr_req;

  assign ten       = ctrl_q[0];
  assign tie       = ctrl_q[1];
  assign chain_sel = CAN_CHAIN && ctrl_q[2];
  assign tick      = run && (chain_sel ? chain_in : 1'b1);
  assign load_now  = ten && !started_q && run;
  assign step      = ten && started_q && tick;
  assign expire    = step && (cnt_q == '0);
  assign clr_req   = flag_wr && wdata[0];
  assign irq       = flag_q && tie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q      <= '0;
      ctrl_q    <= '0;
      started_q <= 1'b0;
      cnt_q     <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (ld_wr) ld_q <= wdata;
      if (ctrl_wr) ctrl_q <= {CAN_CHAIN ? wdata[2] : 1'b0, wdata[1:0]};
      if (!ten) started_q <= 1'b0;
      else if (load_now) started_q <= 1'b1;
      if (load_now) cnt_q <= ld_q;
      else if (step) cnt_q <= DATA_W'(next_count(32'(cnt_q), 32'(ld_q)));
      if (expire) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(ld_q)) && flag_q); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !tick) |=> $stable(cnt_q)); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !flag_q); // R7
  AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R7
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  import ttb_pkg::*;

  logic frz_en_q, stop_q, run;
  logic mcr_hit, mcr_wr;
  logic [NUM_CH-1:0] ld_hit, cnt_hit, ctrl_hit, flag_hit;
  logic [NUM_CH-1:0] ld_wr, ctrl_wr, flag_wr;
  logic [NUM_CH-1:0] exp_vec, flag_vec;
  logic [DATA_W-1:0] ld_arr   [NUM_CH];
  logic [DATA_W-1:0] cnt_arr  [NUM_CH];
  logic [CTRL_W-1:0] ctrl_arr [NUM_CH];

  assign run = !stop_q && !(frz_en_q && freeze_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_en_q <= 1'b0;
      stop_q   <= 1'b1;
    end else if (mcr_wr) begin
      frz_en_q <= wdata[0];
      stop_q   <= wdata[1];
    end
  end

  ttb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .addr(addr), .wr_en(wr_en),
    .mcr_hit(mcr_hit), .ld_hit(ld_hit), .cnt_hit(cnt_hit),
    .ctrl_hit(ctrl_hit), .flag_hit(flag_hit),
    .mcr_wr(mcr_wr), .ld_wr(ld_wr), .ctrl_wr(ctrl_wr), .flag_wr(flag_wr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic chain_src;
    if (i == 1) begin : g_cas
      assign chain_src = exp_vec[0];
    end else begin : g_nocas
      assign chain_src = 1'b0;
    end
    ttb_channel #(.DATA_W(DATA_W), .CAN_CHAIN(i == 1)) ch_i (
      .clk(clk), .rst_n(rst_n), .run(run), .chain_in(chain_src),
      .ld_wr(ld_wr[i]), .ctrl_wr(ctrl_wr[i]), .flag_wr(flag_wr[i]),
      .wdata(wdata),
      .ld_q(ld_arr[i]), .cnt_q(cnt_arr[i]), .ctrl_q(ctrl_arr[i]),
      .flag_q(flag_vec[i]), .expire(exp_vec[i]), .irq(irq[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (mcr_hit) rdata = DATA_W'({stop_q, frz_en_q});
      for (int i = 0; i < NUM_CH; i++) begin
        if (ld_hit[i])   rdata = ld_arr[i];
        if (cnt_hit[i])  rdata = cnt_arr[i];
        if (ctrl_hit[i]) rdata = DATA_W'(ctrl_arr[i]);
        if (flag_hit[i]) rdata = DATA_W'(flag_vec[i]);
      end
    end
  end

  AST_STOP_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (exp_vec == '0)); // R3
  AST_STOP_NO_NEW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> ((flag_vec & ~$past(flag_vec)) == '0)); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flag_vec) == '0)); // R8
endmodule

// File: tb/tick_timer_bank_tb_top.sv
`timescale 1ns/1ps
module tick_timer_bank_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze_in = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer_bank #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .freeze_in(freeze_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] ra(input int ch, input int k);
    return AW'(8'h40 + 4 * ch + k);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; consumes one cycle
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; rd_en = 1'b1;
    #0.5;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(8'h00, v); check("R1 mcr", v, 32'h2);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++) begin
        rd(ra(c, k), v); check("R1 chreg", v, 0);
      end
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_stopped();
    logic [DW-1:0] v;
    wr(ra(0, 0), 5);
    wr(ra(0, 2), 3);
    step(8);
    rd(ra(0, 1), v); check("R3 count held", v, 0);
    rd(ra(0, 3), v); check("R3 no flag", v, 0);
    wr(ra(0, 2), 0);
  endtask

  task automatic t_periodic();
    logic [DW-1:0] v;
    wr(8'h00, 0);
    wr(ra(0, 0), 3);
    wr(ra(0, 2), 3);
    step(1);
    rd(ra(0, 1), v); check("R4 loaded", v, 3);
    step(1);
    rd(ra(0, 1), v); check("R4 decrement", v, 2);
    step(2);
    rd(ra(0, 1), v); check("R5 at zero", v, 0);
    rd(ra(0, 3), v); check("R5 flag not yet", v, 0);
    step(1);
    rd(ra(0, 1), v); check("R5 reload", v, 3);
    rd(ra(0, 3), v); check("R5 flag set", v, 1);
    check("R8 irq on", 32'(irq[0]), 1);
    step(4);
    rd(ra(0, 1), v); check("R5 period", v, 3);
  endtask

  task automatic t_flag();
    logic [DW-1:0] v;
    wr(ra(0, 2), 2);
    check("R8 irq with tie", 32'(irq[0]), 1);
    wr(ra(0, 3), 0);
    rd(ra(0, 3), v); check("R7 write 0 keeps", v, 1);
    wr(ra(0, 2), 0);
    check("R8 irq masked", 32'(irq[0]), 0);
    rd(ra(0, 3), v); check("R8 flag stays", v, 1);
    wr(ra(0, 2), 2);
    wr(ra(0, 3), 1);
    rd(ra(0, 3), v); check("R7 w1c", v, 0);
    check("R8 irq off", 32'(irq[0]), 0);
    wr(ra(0, 2), 0);
  endtask

  task automatic t_reload();
    logic [DW-1:0] v;
    wr(ra(0, 0), 9);
    wr(ra(0, 2), 1);
    step(1);
    rd(ra(0, 1), v); check("R6 start", v, 9);
    wr(ra(0, 0), 2);
    rd(ra(0, 1), v); check("R6 not aborted", v, 8);
    step(8);
    rd(ra(0, 1), v); check("R6 old run to zero", v, 0);
    step(1);
    rd(ra(0, 1), v); check("R6 new load at reload", v, 2);
    wr(ra(0, 0), 6);
    wr(ra(0, 2), 0);
    wr(ra(0, 2), 1);
    step(1);
    rd(ra(0, 1), v); check("R6 restart", v, 6);
    wr(ra(0, 2), 0);
    wr(ra(0, 3), 1);
  endtask

  task automatic t_freeze();
    logic [DW-1:0] a, b;
    wr(ra(2, 0), 50);
    wr(ra(2, 2), 1);
    step(2);
    freeze_in = 1'b1;
    step(1);
    rd(ra(2, 1), a); step(3); rd(ra(2, 1), b);
    check("R9 no effect w/o bit", a - b, 3);
    wr(8'h00, 1);
    rd(ra(2, 1), a); step(3); rd(ra(2, 1), b);
    check("R9 frozen", b, a);
    freeze_in = 1'b0;
    step(1);
    rd(ra(2, 1), a); step(3); rd(ra(2, 1), b);
    check("R9 resumes", a - b, 3);
    wr(8'h00, 0);
    wr(ra(2, 2), 0);
  endtask

  task automatic t_chain();
    logic [DW-1:0] a, b;
    wr(ra(0, 0), 1);
    wr(ra(0, 2), 1);
    wr(ra(1, 0), 1000);
    wr(ra(1, 2), 5);
    rd(ra(1, 2), a); check("R10 ctrl readback", a, 5);
    step(3);
    rd(ra(1, 1), a); step(10); rd(ra(1, 1), b);
    check("R10 cascade rate", a - b, 5);
    wr(ra(2, 2), 4);
    rd(ra(2, 2), a); check("R10 bit2 ignored ch2", a, 0);
    wr(ra(0, 2), 0);
    wr(ra(1, 2), 0);
  endtask

  task automatic t_map();
    logic [DW-1:0] v;
    wr(8'h3F, 32'hFFFF_FFFF);
    rd(8'h3F, v); check("R2 unmapped low", v, 0);
    wr(ra(NCH, 0), 32'h1234);
    rd(ra(NCH, 0), v); check("R2 unmapped high", v, 0);
    rd(8'h00, v); check("R2 mcr unchanged", v, 0);
    rd(ra(3, 1), v);
    wr(ra(3, 1), 32'hABCD);
    begin
      logic [DW-1:0] w;
      rd(ra(3, 1), w); check("R2 count read-only", w, v);
    end
  endtask

  task automatic t_full();
    logic [DW-1:0] v;
    wr(ra(3, 0), 32'hFFFF_FFFF);
    wr(ra(3, 2), 1);
    step(1);
    rd(ra(3, 1), v); check("R5 full load", v, 32'hFFFF_FFFF);
    step(1);
    rd(ra(3, 1), v); check("R5 full step", v, 32'hFFFF_FFFE);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_stopped();
    t_periodic();
    t_flag();
    t_reload();
    t_freeze();
    t_chain();
    t_map();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule